// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the per-processor timer of a local interrupt controller. Software loads an initial count. The timer then counts elapsed ticks, where one tick is a power-of-two number of input clock cycles. When a period ends, the timer raises a one-cycle interrupt request that carries a programmed 8-bit vector. A timer-control word holds that vector, a mask bit and a mode bit. The mode bit selects whether the timer fires once or repeats.

A period is always the initial count plus one ticks long. The readable current count is derived from the ticks that have passed since the last load. Software uses the block through a single write port with a 2-bit select and through a current-count output that is always valid. Interrupt acceptance and priority handling happen elsewhere.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the control word is masked with vector 0 and one-shot mode, the initial count and divide shift are 0, `cur_count` reads 0 and `irq_valid` is low.
- R2: A write with `wr_sel`=1 loads `wr_data` as the initial count, zeroes the elapsed time and restarts the prescaler; on the next cycle `cur_count` equals the written value.
- R3: A write with `wr_sel`=2 sets the divide shift from `wr_data[2:0]` (code k divides by 2^k) and restarts the prescaler; one tick then spans 2^k clock cycles.
- R4: In one-shot mode (control bit 17 = 0), with initial count N and shift k, the interrupt fires exactly once, on the clock edge (N+1)·2^k cycles after the load edge.
- R5: In periodic mode (control bit 17 = 1), the interrupt fires on every edge that is a whole multiple of (N+1)·2^k cycles after the load edge.
- R6: While the mask bit (control bit 16) is set, `irq_valid` stays low, but counting and `cur_count` continue unchanged.
- R7: An initial count of zero stops the timer in both modes: no interrupt is raised and `cur_count` reads 0.
- R8: Rewriting the initial count while the timer runs discards the old schedule, and the next expiry is timed from the new load edge.
- R9: `irq_valid` is a pulse of one cycle, and `irq_vector` carries control bits [7:0] during that cycle.
- R10: A write with `wr_sel`=3 has no effect on the count, the schedule or the interrupt.
- R11: With t elapsed ticks, `cur_count` reads N − (t mod (N+1)) in periodic mode. In one-shot mode it reads N − t, and 0 once t ≥ N.
- R12: A write with `wr_sel`=0 loads the control word (vector in bits [7:0], mask in bit 16, periodic in bit 17) without restarting the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control word, 1 initial count, 2 divide, 3 unused |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count read value |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
The hardest cases to reach are the expiry edges of a periodic timer running with a divided clock, together with a rewrite that lands between two scheduled expiries. A timing mistake in either case moves a pulse by one edge and nothing else. The bench therefore predicts the interrupt and the count for every single cycle after a load, working from the elapsed-cycle arithmetic. It reloads the initial count mid-period and writes to the unused select mid-run, so that any stale schedule shows up as a pulse on the wrong cycle.

// File: rtl/lit_pkg.sv
package lit_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_INIT = 2'd1,
      SEL_DIV  = 2'd2,
      SEL_NONE = 2'd3
   } wr_target_e;

   localparam int CTRL_MASK_POS = 16;
   localparam int CTRL_MODE_POS = 17;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   localparam int PRE_W = (2 ** SHIFT_W) - 1;

   generate
      if (SHIFT_W < 1 || SHIFT_W > 4) begin : g_bad_shift
         $error("tick_prescaler: SHIFT_W must be 1..4");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] limit;

   // thermometer limit: low 'shift' bits set, i.e. 2^shift - 1
   generate
      for (genvar i = 0; i < PRE_W; i++) begin : g_limit
         assign limit[i] = (shift > SHIFT_W'(i));
      end
   endgenerate

   assign tick = !restart && (pre_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pre_q <= '0;
      else if (restart)     pre_q <= '0;
      else if (tick)        pre_q <= '0;
      else                  pre_q <= pre_q + PRE_W'(1);
   end

   // R3: a restart always leaves the prescaler at its start value
   a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_q == '0));
endmodule

// File: rtl/period_counter.sv
module period_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             tick,
   input  logic [CNT_W-1:0] init_cnt,
   input  logic             periodic,
   output logic [CNT_W-1:0] phase,
   output logic             expire,
   output logic             done
);
   generate
      if (CNT_W < 18) begin : g_bad_width
         $error("period_counter: CNT_W must be at least 18");
      end
   endgenerate

   logic active;

   assign active = (init_cnt != '0) && !done;
   assign expire = tick && active && !load && (phase == init_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         done  <= 1'b0;
      end else if (load) begin
         phase <= '0;
         done  <= 1'b0;
      end else if (tick && active) begin
         if (phase == init_cnt) begin
            phase <= '0;
            if (!periodic) done <= 1'b1;
         end else begin
            phase <= phase + CNT_W'(1);
         end
      end
   end

   // R11: ticks within a period never pass the initial count
   a_r11_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= init_cnt);
   // R4: a finished one-shot timer has no further expiry
   a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |-> !expire);
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
   parameter int CNT_W   = 32,
   parameter int SHIFT_W = 3,
   parameter int VEC_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cur_count,
   output logic             irq_valid,
   output logic [VEC_W-1:0] irq_vector
);
   import lit_pkg::*;

   generate
      if (VEC_W < 1 || VEC_W > CTRL_MASK_POS) begin : g_bad_vec
         $error("irq_countdown_timer: VEC_W must be 1..16");
      end
      if (CNT_W <= CTRL_MODE_POS) begin : g_bad_cnt
         $error("irq_countdown_timer: CNT_W too small for control word");
      end
   endgenerate

   logic [VEC_W-1:0]   ctrl_vec;
   logic               ctrl_mask;
   logic               ctrl_periodic;
   logic [SHIFT_W-1:0] div_shift;
   logic [CNT_W-1:0]   init_cnt;
   logic               wr_ctrl, wr_init, wr_div;
   logic               tick, expire, done;
   logic [CNT_W-1:0]   phase;

   assign wr_ctrl = wr_en && (wr_target_e'(wr_sel) == SEL_CTRL);
   assign wr_init = wr_en && (wr_target_e'(wr_sel) == SEL_INIT);
   assign wr_div  = wr_en && (wr_target_e'(wr_sel) == SEL_DIV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_vec      <= '0;
         ctrl_mask     <= 1'b1;
         ctrl_periodic <= 1'b0;
         div_shift     <= '0;
         init_cnt      <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_vec      <= wr_data[VEC_W-1:0];
            ctrl_mask     <= wr_data[CTRL_MASK_POS];
            ctrl_periodic <= wr_data[CTRL_MODE_POS];
         end
         if (wr_div)  div_shift <= wr_data[SHIFT_W-1:0];
         if (wr_init) init_cnt  <= wr_data;
      end
   end

   tick_prescaler #(.SHIFT_W(SHIFT_W)) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_init || wr_div),
      .shift   (div_shift),
      .tick    (tick)
   );

   period_counter #(.CNT_W(CNT_W)) u_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_init),
      .tick     (tick),
      .init_cnt (init_cnt),
      .periodic (ctrl_periodic),
      .phase    (phase),
      .expire   (expire),
      .done     (done)
   );

   assign cur_count = (init_cnt == '0 || done) ? '0 : (init_cnt - phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_valid <= expire && !ctrl_mask;
         if (expire && !ctrl_mask) irq_vector <= ctrl_vec;
      end
   end

   // R6: masked entry never raises a request
   a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_mask) |-> !irq_valid);
   // R7: zero initial count never raises a request
   a_r7_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_cnt == '0) |-> !irq_valid);
   // R9: request lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> !irq_valid);
   // R2: loaded value is visible on the next cycle
   a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_init) |-> (cur_count == $past(wr_data)));
endmodule

// File: tb/test_irq_countdown_timer.sv
module test_irq_countdown_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] cur_count;
   logic        irq_valid;
   logic [7:0]  irq_vector;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   irq_countdown_timer i_irq_countdown_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .cur_count(cur_count),
      .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   task automatic check(string tag, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // caller stands at a negedge; returns at the negedge after the write edge
   task automatic wr(logic [1:0] sel, logic [31:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [31:0] ctrl_word(logic [7:0] vec, bit masked, bit per);
      return {14'd0, per, masked, 8'd0, vec};
   endfunction

   // n = clock edges since the load edge
   task automatic observe(string tag, longint init, int s, bit per, bit masked,
                          logic [7:0] vec, int from, int upto);
      for (int n = from; n <= upto; n++) begin
         longint period = (init + 1) << s;
         longint t = n >> s;
         bit exp_irq = !masked && init != 0 && n > 0 && (n % period) == 0
                       && (per || n == period);
         longint exp_cnt;
         if (init == 0) exp_cnt = 0;
         else if (per)  exp_cnt = init - (t % (init + 1));
         else           exp_cnt = (t >= init) ? 0 : init - t;
         check({tag, " irq"}, irq_valid, exp_irq);
         check("R11 count", cur_count, exp_cnt);
         if (exp_irq) check("R9 vector", irq_vector, vec);
         @(negedge clk);
      end
   endtask

   task automatic scenario(string tag, logic [7:0] vec, longint init, int s,
                           bit per, bit masked, int cycles);
      wr(2'd0, ctrl_word(vec, masked, per));   // R12 control write
      wr(2'd2, 32'(s));                        // R3 divide write
      wr(2'd1, 32'(init));                     // R2 load
      check("R2 load", cur_count, init == 0 ? 0 : init);
      observe(tag, init, s, per, masked, vec, 0, cycles);
   endtask

   task automatic t_reset;
      check("R1 count", cur_count, 0);
      check("R1 irq", irq_valid, 0);
      check("R1 vector", irq_vector, 0);
   endtask

   task automatic t_reload;
      wr(2'd0, ctrl_word(8'h5a, 1'b0, 1'b0));
      wr(2'd2, 32'd0);
      wr(2'd1, 32'd5);
      observe("R8", 5, 0, 1'b0, 1'b0, 8'h5a, 0, 3);
      wr(2'd1, 32'd5);   // R8 reload mid-period
      observe("R8", 5, 0, 1'b0, 1'b0, 8'h5a, 0, 12);
   endtask

   task automatic t_unused_sel;
      wr(2'd0, ctrl_word(8'h33, 1'b0, 1'b0));
      wr(2'd2, 32'd1);
      wr(2'd1, 32'd4);
      observe("R10", 4, 1, 1'b0, 1'b0, 8'h33, 0, 1);
      wr(2'd3, 32'hffff_ffff);   // R10 ignored write
      observe("R10", 4, 1, 1'b0, 1'b0, 8'h33, 3, 16);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      scenario("R4", 8'h41, 3, 0, 1'b0, 1'b0, 30);
      scenario("R5", 8'h82, 2, 1, 1'b1, 1'b0, 40);
      scenario("R3", 8'h17, 1, 2, 1'b0, 1'b0, 20);
      scenario("R3", 8'hc4, 1, 3, 1'b1, 1'b0, 50);
      scenario("R6", 8'h99, 2, 0, 1'b1, 1'b1, 30);
      scenario("R7", 8'h11, 0, 0, 1'b1, 1'b0, 20);
      scenario("R7", 8'h12, 0, 1, 1'b0, 1'b0, 20);
      t_reload();
      t_unused_sel();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule